// File: doc/BRIEF.md
# Keyboard Event Queue

This block sits between a keyboard front end, which delivers one raw 8-bit scancode per cycle with a valid strobe, and a host processor that collects key events over a simple word-addressed register bus. Each scancode becomes a 32-bit event word. The low seven bits of the byte are kept. A one-byte extension prefix sets a marker bit in the following event. The top bit of the byte is moved to bit 31 to mark a key release. Finished words wait in a first-in first-out queue until the host collects them.

The host reads the oldest event from a data register, and that read also removes the event. Other registers report how many events are waiting, the queue's capacity and a fixed identification word, and hold an interrupt enable. A level interrupt stays asserted while events are waiting and the enable is set. All read data, the read-valid flag and the interrupt come from registers.

Top module: `kbdq_event_queue`

## Requirements
- R1: A synchronous active-high reset empties the queue, disarms the prefix, clears the interrupt enable and drives `irq`, `bus_rvalid` and `bus_rdata` to zero.
- R2: The word index is the byte address shifted right by two. Word 0 reads 0xC51D0002 and word 4 reads the capacity (16 by default). Any index above 4 reads zero.
- R3: For a scancode that is not a prefix, the event word has bit 31 equal to byte bit 7, bits 6..0 equal to byte bits 6..0, and bit 7 equal to the armed prefix state. All other bits are zero.
- R4: A 0xE0 byte that arrives with no prefix armed queues nothing and arms the prefix. The next queued event then carries bit 7, and the prefix disarms after that event.
- R5: A 0xE0 byte that arrives while the prefix is armed is an ordinary code and produces 0x800000E0.
- R6: A new event that arrives while the queue holds 16 entries and no pop happens in that cycle is dropped. Occupancy never exceeds capacity.
- R7: A read of word 1 returns the oldest event and removes it. On an empty queue it returns 0xFFFFFFFF and changes nothing.
- R8: Word 3 keeps only bit 0 of the written data and reads it back. `irq` is high exactly when that bit is set and the queue is non-empty, as of the previous edge.
- R9: A read of word 2 returns the number of queued events.
- R10: When an event arrives in the same cycle as a pop of a non-empty queue, both take effect and the occupancy stays the same, even when the queue is full.
- R11: A read request is answered at the next edge: `bus_rvalid` is high for exactly one cycle with the data in `bus_rdata`.
- R12: Writes to words 0, 1, 2 and 4, and to unmapped words, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | Scancode strobe |
| code_byte | input | 8 | Raw scancode |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle: a scancode arriving through the strobe and a host read of the data register that pops the queue. The bench provokes the collision with a half-full queue and again with a full one. In the full case the arriving event must be accepted, because the pop frees a slot in the same edge. A behavioural queue model predicts the returned word, the unchanged occupancy and the later ordering on every clock. That ordering is confirmed by draining the queue and comparing each popped word.

// File: rtl/kbdq_pkg.sv
package kbdq_pkg;
  localparam int EVT_W = 32;
  localparam logic [EVT_W-1:0] ID_WORD    = 32'hC51D_0002;
  localparam logic [EVT_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;
  localparam logic [7:0]       PREFIX_BYTE = 8'hE0;

  typedef enum int {
    IDX_ID     = 0,
    IDX_DATA   = 1,
    IDX_COUNT  = 2,
    IDX_ENABLE = 3,
    IDX_SIZE   = 4
  } reg_idx_e;
endpackage

// File: rtl/kbdq_encoder.sv
module kbdq_encoder
  import kbdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             code_valid,
  input  logic [7:0]       code_byte,
  output logic             push_req,
  output logic [EVT_W-1:0] push_word,
  output logic             armed
);
  logic armed_q;
  logic starts_prefix;

  assign starts_prefix = (code_byte == PREFIX_BYTE) && !armed_q;
  assign armed = armed_q;

  always_comb begin
    push_req             = code_valid && !starts_prefix;
    push_word            = '0;
    push_word[EVT_W-1]   = code_byte[7];
    push_word[7]         = armed_q;
    push_word[6:0]       = code_byte[6:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      armed_q <= 1'b0;
    else if (code_valid)
      armed_q <= starts_prefix;
  end
endmodule

// File: rtl/kbdq_fifo.sv
module kbdq_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             push_ok,
  output logic             pop_ok
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign pop_ok  = pop_req && (count_q != '0);
  assign push_ok = push_req && ((count_q != CNT_W'(DEPTH)) || pop_ok);

  always_comb begin
    count_nxt = count_q;
    if (push_ok && !pop_ok) count_nxt = count_q + 1'b1;
    else if (pop_ok && !push_ok) count_nxt = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count_q <= count_nxt;
    end
  end

  assign head  = mem[rd_ptr];
  assign count = count_q;
endmodule

// File: rtl/kbdq_regs.sv
module kbdq_regs
  import kbdq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  localparam int IDX_W = ADDR_W - 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [EVT_W-1:0]  bus_wdata,
  input  logic [EVT_W-1:0]  head,
  input  logic [CNT_W-1:0]  count,
  output logic              pop_req,
  output logic              int_en_nxt,
  output logic [EVT_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  logic [IDX_W-1:0] idx;
  logic             rd_req, wr_req;
  logic             int_en_q;
  logic [EVT_W-1:0] rd_mux;
  logic             unused_bits;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign rd_req      = bus_sel && !bus_wr;
  assign wr_req      = bus_sel && bus_wr;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[EVT_W-1:1]};

  assign pop_req    = rd_req && (idx == IDX_W'(IDX_DATA));
  assign int_en_nxt = (wr_req && (idx == IDX_W'(IDX_ENABLE))) ? bus_wdata[0] : int_en_q;

  always_comb begin
    rd_mux = '0;
    if (idx == IDX_W'(IDX_ID))          rd_mux = ID_WORD;
    else if (idx == IDX_W'(IDX_DATA))   rd_mux = (count == '0) ? EMPTY_WORD : head;
    else if (idx == IDX_W'(IDX_COUNT))  rd_mux = EVT_W'(count);
    else if (idx == IDX_W'(IDX_ENABLE)) rd_mux = EVT_W'(int_en_q);
    else if (idx == IDX_W'(IDX_SIZE))   rd_mux = EVT_W'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en_q   <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      int_en_q   <= int_en_nxt;
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/kbdq_event_queue.sv
module kbdq_event_queue
  import kbdq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_valid,
  input  logic [7:0]        code_byte,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  logic             enc_push;
  logic [EVT_W-1:0] enc_word;
  logic             enc_armed;
  logic             pop_req;
  logic [EVT_W-1:0] fifo_head;
  logic [CNT_W-1:0] fifo_count, fifo_count_nxt;
  logic             fifo_push_ok, fifo_pop_ok;
  logic             int_en_nxt;

  kbdq_encoder u_enc (
    .clk        (clk),
    .rst        (rst),
    .code_valid (code_valid),
    .code_byte  (code_byte),
    .push_req   (enc_push),
    .push_word  (enc_word),
    .armed      (enc_armed)
  );

  kbdq_fifo #(.DEPTH(DEPTH), .WIDTH(EVT_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_req  (enc_push),
    .push_data (enc_word),
    .pop_req   (pop_req),
    .head      (fifo_head),
    .count     (fifo_count),
    .count_nxt (fifo_count_nxt),
    .push_ok   (fifo_push_ok),
    .pop_ok    (fifo_pop_ok)
  );

  kbdq_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .head       (fifo_head),
    .count      (fifo_count),
    .pop_req    (pop_req),
    .int_en_nxt (int_en_nxt),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= int_en_nxt && (fifo_count_nxt != '0);
  end
endmodule

// File: rtl/kbdq_checker.sv
module kbdq_checker #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              code_valid,
  input logic [7:0]        code_byte,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              irq,
  input logic [CNT_W-1:0]  occ,
  input logic              armed,
  input logic              push_ok,
  input logic              pop_ok
);
  logic rd_req, data_rd;
  logic unused_bits;
  assign rd_req      = bus_sel && !bus_wr;
  assign data_rd     = rd_req && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign unused_bits = ^bus_addr[1:0];

  // R6
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  // R8
  a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (rst)
    irq |-> (occ != '0));

  // R11
  a_r11_rvalid_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);
  a_r11_rvalid_one_shot: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);

  // R7
  a_r7_empty_read: assert property (@(posedge clk) disable iff (rst)
    (data_rd && occ == '0 && !code_valid) |=> (bus_rdata == 32'hFFFF_FFFF) && (occ == '0));

  // R4
  a_r4_prefix_silent: assert property (@(posedge clk) disable iff (rst)
    (code_valid && code_byte == 8'hE0 && !armed && !data_rd) |=> $stable(occ) && armed);

  // R10
  a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(occ));
endmodule

bind kbdq_event_queue kbdq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .code_valid (code_valid),
  .code_byte  (code_byte),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq        (irq),
  .occ        (fifo_count),
  .armed      (enc_armed),
  .push_ok    (fifo_push_ok),
  .pop_ok     (fifo_pop_ok)
);

// File: tb/tb_kbdq_event_queue.sv
module tb_kbdq_event_queue;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          code_valid = 1'b0;
  logic [7:0]    code_byte = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          irq;

  always #4 clk = ~clk;

  kbdq_event_queue #(.ADDR_W(AW), .DEPTH(16)) dut (
    .clk(clk), .rst(rst), .code_valid(code_valid), .code_byte(code_byte),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [31:0] q[$];
  bit          m_armed = 0, m_en = 0;
  bit          e_irq = 0, e_rvalid = 0;
  logic [31:0] e_rdata = '0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    int          idx;
    bit          do_pop, do_push;
    logic [31:0] w;
    @(posedge clk);
    idx = int'(bus_addr[AW-1:2]);
    do_pop = 0; do_push = 0; w = '0;
    if (rst) begin
      q.delete(); m_armed = 0; m_en = 0;
      e_irq = 0; e_rvalid = 0; e_rdata = '0;
    end else begin
      e_rvalid = bus_sel && !bus_wr;
      if (e_rvalid) begin
        case (idx)
          0: e_rdata = 32'hC51D0002;
          1: begin
               if (q.size() == 0) e_rdata = 32'hFFFFFFFF;
               else begin e_rdata = q[0]; do_pop = 1; end
             end
          2: e_rdata = q.size();
          3: e_rdata = {31'b0, m_en};
          4: e_rdata = 16;
          default: e_rdata = 0;
        endcase
      end
      if (code_valid) begin
        if (code_byte == 8'hE0 && !m_armed) m_armed = 1;
        else begin
          w = {code_byte[7], 23'b0, m_armed, code_byte[6:0]};
          m_armed = 0;
          do_push = 1;
        end
      end
      if (bus_sel && bus_wr && idx == 3) m_en = bus_wdata[0];
      if (do_pop) void'(q.pop_front());
      if (do_push && q.size() < 16) q.push_back(w);
      e_irq = m_en && (q.size() > 0);
    end
    @(negedge clk);
    check(tag, "irq", {31'b0, irq}, {31'b0, e_irq});
    check(tag, "rvalid", {31'b0, bus_rvalid}, {31'b0, e_rvalid});
    if (e_rvalid || rst) check(tag, "rdata", bus_rdata, e_rdata);
  endtask

  task automatic drive(bit sel, bit wr, int addr, logic [31:0] wd, bit cv, logic [7:0] cb, string tag);
    bus_sel = sel; bus_wr = wr; bus_addr = AW'(addr); bus_wdata = wd;
    code_valid = cv; code_byte = cb;
    cyc(tag);
    bus_sel = 0; bus_wr = 0; code_valid = 0;
  endtask

  task automatic key(logic [7:0] b, string tag);  drive(0, 0, 0, 0, 1, b, tag); endtask
  task automatic rd(int a, string tag);           drive(1, 0, a, 0, 0, 0, tag); endtask
  task automatic wr(int a, logic [31:0] d, string tag); drive(1, 1, a, d, 0, 0, tag); endtask

  task automatic reset_pulse(string tag);
    rst = 1; cyc(tag); cyc(tag); rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    reset_pulse("R1");
    // R1: state after reset
    rd('h8, "R1"); rd('hC, "R1"); rd('h4, "R1");
    // R2: fixed words and unmapped space
    rd('h0, "R2"); rd('h10, "R2"); rd('h40, "R2"); rd('h14, "R2");
    // R8: only bit 0 kept
    wr('hC, 32'hFFFF_FFFE, "R8"); rd('hC, "R8");
    wr('hC, 32'hFFFF_FFFF, "R8"); rd('hC, "R8");
    // R3 / R9 / R7
    key(8'h1C, "R3"); key(8'h9C, "R3"); key(8'h7F, "R3");
    rd('h8, "R9");
    rd('h4, "R7"); rd('h4, "R7"); rd('h4, "R7");
    rd('h4, "R7"); rd('h8, "R7");
    // R4 / R5
    key(8'hE0, "R4"); rd('h8, "R4"); key(8'h48, "R4");
    key(8'hE0, "R4"); key(8'hC8, "R4");
    key(8'hE0, "R5"); key(8'hE0, "R5"); key(8'h10, "R5");
    for (int i = 0; i < 5; i++) rd('h4, "R4");
    // R10: collision on a partly filled queue
    key(8'h21, "R10"); key(8'h22, "R10");
    drive(1, 0, 'h4, 0, 1, 8'h23, "R10");
    rd('h8, "R10"); rd('h4, "R10"); rd('h4, "R10");
    // R6: overfill
    for (int i = 0; i < 20; i++) key(8'(8'h01 + i), "R6");
    rd('h8, "R6");
    // R10: collision at full
    drive(1, 0, 'h4, 0, 1, 8'h30, "R10");
    rd('h8, "R10");
    // R12: writes to read-only and unmapped words
    wr('h4, 32'h0, "R12"); wr('h8, 32'h0, "R12"); wr('h0, 32'h0, "R12");
    wr('h10, 32'h1, "R12"); wr('h80, 32'h0, "R12");
    rd('h8, "R12"); rd('h0, "R12"); rd('h10, "R12");
    // R8: disable with data waiting, then enable again
    wr('hC, 32'h0, "R8"); idle_n(2, "R8");
    wr('hC, 32'h1, "R8");
    // drain, checking order
    for (int i = 0; i < 17; i++) rd('h4, "R7");
    rd('h8, "R9");
    // R11: back to back reads and gaps
    rd('h0, "R11"); rd('h0, "R11"); idle_n(1, "R11"); rd('h10, "R11");
    // R1: reset with prefix armed and data queued
    key(8'h55, "R1"); key(8'hE0, "R1");
    reset_pulse("R1");
    rd('h8, "R1"); rd('hC, "R1");
    key(8'h20, "R1"); rd('h4, "R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic idle_n(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask
endmodule